// File: doc/BRIEF.md
# Fully Associative Tag Directory

This block is the address-mapping directory of a small fully associative cache. It keeps one entry per cache block. Each entry holds a valid flag and, as its tag, the main-memory block number now loaded in that cache block. A byte address comes in on a single port. The upper bits are the block number and the lower bits are the byte offset within the block. The directory compares the block number against every valid entry in the same cycle. On a hit it reports which cache block holds the data and forms the cache address from that index and the untouched offset.

On a miss, the surrounding controller issues a fill. The fill writes the requested block number into an entry that the controller picks. Two outputs help with that choice. One gives the lowest-numbered free entry, and the other is a full flag that says a victim must be supplied from outside. A synchronous invalidate-all input empties the directory in one cycle.

The defaults describe 64 MB of byte-addressed memory split into 4 KB blocks, held in an 8-block cache. That gives a 14-bit tag, a 12-bit offset and a 3-bit entry index.

Top module: `fa_tag_dir`

## Requirements
- R1: After reset no entry is valid. The outputs read `hit_o`=0, `full_o`=0, `free_any_o`=1 and `free_idx_o`=0.
- R2: Lookup is combinational. `hit_o` is 1 exactly when some valid entry's tag equals `addr_i[25:12]`. `hit_idx_o` is the index of that entry, and 0 on a miss.
- R3: `cache_addr_o` is `{hit_idx_o, addr_i[11:0]}`. The index occupies bits 14:12 and the offset is passed through unchanged in bits 11:0.
- R4: When `fill_i` is 1 at a rising edge, entry `fill_idx_i` becomes valid with tag `addr_i[25:12]`. A lookup in the same cycle as the fill still reflects the contents from before the fill.
- R5: `free_idx_o` is the lowest-numbered invalid entry, and `free_any_o` is 1 when at least one entry is invalid.
- R6: When all entries are valid, `full_o` is 1, `free_any_o` is 0 and `free_idx_o` is 0.
- R7: When `inv_all_i` is 1 at a rising edge, every entry becomes invalid. This has priority over a fill in the same cycle.
- R8: A fill into an entry that is already valid replaces its tag. The old block number then misses and the new one hits at that index.
- R9: If several valid entries hold the same tag, the hit reports the lowest index among them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr_i | input | 26 | Main-memory byte address being looked up or filled |
| fill_i | input | 1 | Install the block number of `addr_i` at the next edge |
| fill_idx_i | input | 3 | Entry written by a fill |
| inv_all_i | input | 1 | Clear all valid flags at the next edge |
| hit_o | output | 1 | Block number found in a valid entry |
| hit_idx_o | output | 3 | Matching entry index |
| cache_addr_o | output | 15 | Cache byte address on a hit |
| free_any_o | output | 1 | At least one entry is invalid |
| free_idx_o | output | 3 | Lowest invalid entry |
| full_o | output | 1 | Every entry is valid |

## Verification
Corrupt state in this directory shows up at the ports in the same cycle that it is read. A wrong valid flag changes `full_o` or `free_idx_o` right away. A wrong tag changes `hit_o` for the affected block number as soon as that block number is presented. To expose a bad stored tag, the bench presents all 16384 block numbers against a full directory. Every fill, replacement and invalidate is followed by a lookup in the very next cycle, so an edge-timing fault shows up one cycle after its cause.

// File: rtl/fa_tag_dir.sv
module fa_tag_dir #(
  parameter int ENTRIES  = 8,
  parameter int ADDR_W   = 26,
  parameter int OFFSET_W = 12
) (
  input  logic                                  clk,
  input  logic                                  rst_n,
  input  logic [ADDR_W-1:0]                     addr_i,
  input  logic                                  fill_i,
  input  logic [$clog2(ENTRIES)-1:0]            fill_idx_i,
  input  logic                                  inv_all_i,
  output logic                                  hit_o,
  output logic [$clog2(ENTRIES)-1:0]            hit_idx_o,
  output logic [$clog2(ENTRIES)+OFFSET_W-1:0]   cache_addr_o,
  output logic                                  free_any_o,
  output logic [$clog2(ENTRIES)-1:0]            free_idx_o,
  output logic                                  full_o
);
  localparam int IDX_W = $clog2(ENTRIES);
  localparam int TAG_W = ADDR_W - OFFSET_W;

  logic [ENTRIES-1:0] valid_q;
  logic [TAG_W-1:0]   tag_q [ENTRIES];
  logic [ENTRIES-1:0] match;
  logic [TAG_W-1:0]   req_tag;

  assign req_tag = addr_i[ADDR_W-1:OFFSET_W];

  for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
    assign match[g] = valid_q[g] && (tag_q[g] == req_tag);
  end

  always_comb begin
    hit_idx_o  = '0;
    free_idx_o = '0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (match[i])    hit_idx_o  = IDX_W'(i);
      if (!valid_q[i]) free_idx_o = IDX_W'(i);
    end
  end

  assign hit_o        = |match;
  assign free_any_o   = ~&valid_q;
  assign full_o       = &valid_q;
  assign cache_addr_o = {hit_idx_o, addr_i[OFFSET_W-1:0]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         valid_q <= '0;
    else if (inv_all_i) valid_q <= '0;
    else if (fill_i)    valid_q[fill_idx_i] <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (fill_i && !inv_all_i) tag_q[fill_idx_i] <= req_tag;
  end
endmodule

// File: rtl/fa_tag_dir_chk.sv
module fa_tag_dir_chk #(
  parameter int ENTRIES  = 8,
  parameter int ADDR_W   = 26,
  parameter int OFFSET_W = 12
) (
  input logic                                clk,
  input logic                                rst_n,
  input logic [ADDR_W-1:0]                   addr_i,
  input logic                                fill_i,
  input logic [$clog2(ENTRIES)-1:0]          fill_idx_i,
  input logic                                inv_all_i,
  input logic                                hit_o,
  input logic [$clog2(ENTRIES)-1:0]          hit_idx_o,
  input logic [$clog2(ENTRIES)+OFFSET_W-1:0] cache_addr_o,
  input logic                                free_any_o,
  input logic [$clog2(ENTRIES)-1:0]          free_idx_o,
  input logic                                full_o
);
  assert_offset_pass_R3: assert property (@(posedge clk) disable iff (!rst_n)
    cache_addr_o[OFFSET_W-1:0] == addr_i[OFFSET_W-1:0]);

  assert_fill_then_hit_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (fill_i && !inv_all_i) |=> ($stable(addr_i) -> (hit_o && hit_idx_o <= $past(fill_idx_i))));

  assert_full_no_free_R6: assert property (@(posedge clk) disable iff (!rst_n)
    full_o |-> (!free_any_o && free_idx_o == '0));

  assert_free_persists_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (free_any_o && !fill_i) |=> free_any_o);

  assert_inv_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
    inv_all_i |=> (!hit_o && !full_o && free_any_o && free_idx_o == '0));

  assert_miss_idx_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !hit_o |-> hit_idx_o == '0);
endmodule

bind fa_tag_dir fa_tag_dir_chk #(.ENTRIES(ENTRIES), .ADDR_W(ADDR_W), .OFFSET_W(OFFSET_W)) u_chk (.*);

// File: tb/fa_tag_dir_tb.sv
module fa_tag_dir_tb;
  localparam int PERIOD = 10;
  localparam int N = 8;

  logic        clk = 0, rst_n = 0;
  logic [25:0] addr_i = '0;
  logic        fill_i = 0, inv_all_i = 0;
  logic [2:0]  fill_idx_i = '0;
  logic        hit_o, free_any_o, full_o;
  logic [2:0]  hit_idx_o, free_idx_o;
  logic [14:0] cache_addr_o;

  int compared = 0, mismatched = 0, cycles = 0;
  bit ref_v [N];
  logic [13:0] ref_t [N];

  fa_tag_dir u_dut (.*);

  always #(PERIOD/2) clk = ~clk;

  task automatic chk(string rq, int act, int exp);
    compared++;
    if (act != exp) begin
      mismatched++;
      $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
    end
  endtask

  task automatic check_all(string rq);
    int eh = 0, ei = 0, fi = 0, fa = 0, fu = 1;
    for (int i = N - 1; i >= 0; i--) begin
      if (ref_v[i] && ref_t[i] == addr_i[25:12]) begin eh = 1; ei = i; end
      if (!ref_v[i]) begin fi = i; fa = 1; fu = 0; end
    end
    chk({rq, " hit"}, int'(hit_o), eh);
    chk({rq, " idx"}, int'(hit_idx_o), ei);
    chk({rq, " R3 caddr"}, int'(cache_addr_o), (ei << 12) | int'(addr_i[11:0]));
    chk({rq, " R5 free_any"}, int'(free_any_o), fa);
    chk({rq, " R5 free_idx"}, int'(free_idx_o), fi);
    chk({rq, " R6 full"}, int'(full_o), fu);
  endtask

  task automatic step(string rq, bit f, int idx, bit inv, logic [13:0] tag, logic [11:0] off);
    @(negedge clk);
    fill_i = f; fill_idx_i = 3'(idx); inv_all_i = inv; addr_i = {tag, off};
    #1 check_all(rq);
    @(posedge clk);
    if (inv) for (int i = 0; i < N; i++) ref_v[i] = 0;
    else if (f) begin ref_v[idx] = 1; ref_t[idx] = tag; end
  endtask

  initial begin
    while (cycles < 200000) begin @(posedge clk); cycles++; end
    mismatched++;
    $display("FAIL watchdog expired");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    for (int i = 0; i < N; i++) begin ref_v[i] = 0; ref_t[i] = '0; end
    repeat (2) @(negedge clk);
    #1 check_all("R1");
    rst_n = 1;
    // R4 R5: fill at the lowest free entry; same-cycle lookups see old contents
    for (int i = 0; i < N; i++)
      step("R4", 1, i, 0, 14'((i * 1237 + 5) & 16'h3fff), 12'(i * 511));
    step("R6", 0, 0, 0, 14'd5, 12'hfff);
    // R2 R3: exhaustive block-number sweep against a full directory
    for (int t = 0; t < 16384; t++) begin
      @(negedge clk); fill_i = 0; inv_all_i = 0; addr_i = {14'(t), 12'((t * 37) & 12'hfff)};
      #1 check_all("R2");
    end
    // R8: replace entry 3
    step("R8", 1, 3, 0, 14'h2abc, 12'h123);
    step("R8", 0, 0, 0, 14'h2abc, 12'h456);
    step("R8", 0, 0, 0, 14'((3 * 1237 + 5) & 16'h3fff), 12'h0);
    // R9: duplicate tag in entries 1 and 6
    step("R9", 1, 6, 0, 14'((1 * 1237 + 5) & 16'h3fff), 12'h7);
    step("R9", 0, 0, 0, 14'((1 * 1237 + 5) & 16'h3fff), 12'h8);
    // R7: invalidate wins over a simultaneous fill
    step("R7", 1, 2, 1, 14'h1111, 12'h0);
    step("R7", 0, 0, 0, 14'h1111, 12'h0);
    step("R7", 0, 0, 0, 14'((2 * 1237 + 5) & 16'h3fff), 12'h0);
    // R5: out-of-order fills, lowest free follows
    step("R5", 1, 0, 0, 14'h0010, 12'h0);
    step("R5", 1, 1, 0, 14'h0011, 12'h0);
    step("R5", 1, 4, 0, 14'h0012, 12'h0);
    step("R5", 1, 2, 0, 14'h0013, 12'h0);
    step("R5", 0, 0, 0, 14'h0012, 12'habc);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule